// File: doc/BRIEF.md
# Receive Signal-Loss and Clock-Fallback Supervisor

This block sits after the clock-recovery path of a serial receiver and watches the recovered data, which arrives as narrow parallel words on a local clock. When the line stops toggling and stays at one level, all ones or all zeros, the block declares loss of signal. While signal is lost, it holds the parallel receive data at zero and moves the clock-source select to the reference clock. It releases both only after transitions have been present for a long, unbroken window. The set window is short and the clear window is long, so a line that comes back with gaps does not make the select chatter.

A raw lock indication from the recovery PLL crosses into the local clock through a two-flop synchronizer. A pair of filter counters then qualifies it into a loss-of-lock status. Both statuses leave the block active low. From them the block derives a compact state: normal operation, clean signal loss (static line) or dirty signal loss / loss of lock (toggling but unlockable line). All windows are parameters counted in clock cycles.

Top module: `rx_sig_supervisor`

## Requirements
- R1: After synchronous active-high reset, `los_n` = 1, `lol_n` = 1, `use_refclk` = 0, `op_state` = 0 and `rx_data_out` = 0.
- R2: Bit DATA_W-1 of a word is the oldest bit and bit 0 the newest. A transition is any difference between neighbouring bits of a word, or between bit DATA_W-1 and bit 0 of the previous word. A word that is constant inside but differs from the previous word's bit 0 counts as a transition.
- R3: `los_n` falls on the clock edge that samples the LOS_SET_CYC-th word in a row without a transition. After LOS_SET_CYC-1 such words it is still 1.
- R4: `rx_data_out` equals the word sampled on the previous edge, except that it reads all zeros whenever `los_n` is 0.
- R5: `use_refclk` is 1 exactly while `los_n` is 0.
- R6: Loss of signal clears only after LOS_CLR_SLOTS consecutive slots of LOS_SLOT_CYC cycles have each held at least one transition. Slots are counted from the edge that set loss of signal. A slot with no transition restarts the count.
- R7: `lol_n` falls LOL_SET_CYC+2 edges after `pll_lock_raw` goes low and stays low. After LOL_SET_CYC+1 edges it is still 1.
- R8: `lol_n` rises LOL_CLR_CYC+2 edges after `pll_lock_raw` returns high and stays high.
- R9: `op_state` is 0 (normal: `los_n`=1, `lol_n`=1), 1 (clean loss: `los_n`=0, `lol_n`=1) or 2 (dirty loss / loss of lock: `los_n`=1, `lol_n`=0). Loss of signal takes precedence, and `lol_n` reads 1 while `los_n` is 0.
- R10: In state 2 the receive data is not forced to zero and continues to follow the input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local word clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word | input | DATA_W | Recovered parallel receive word |
| pll_lock_raw | input | 1 | Unsynchronized PLL lock indication, 1 = locked |
| rx_data_out | output | DATA_W | Registered receive data, forced to zero during loss of signal |
| los_n | output | 1 | Loss of signal, active low |
| lol_n | output | 1 | Qualified loss of lock, active low |
| use_refclk | output | 1 | Clock-source select, 1 = reference clock |
| op_state | output | 2 | Operating state code |

## Verification
A stuck-run counter that is off by one shows up as `los_n` falling one edge early or late after a quiet run. A mishandled word boundary shows up when a boundary-only transition fails to hold `los_n` high. A slot tracker that does not restart shows up as `los_n` rising before a full unbroken window has passed after a quiet slot, and this is visible within one slot. A wrong synchronizer depth or lock-filter limit moves the `lol_n` edge by a cycle, which is seen at the exact edge. A lost masking of the lock status during signal loss shows up as `op_state` and `lol_n` disagreeing in the same cycle.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL    = 2'd0,
        ST_CLEAN_LOS = 2'd1,
        ST_DIRTY     = 2'd2
    } sup_state_e;
endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[0], d};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= {2{RST_VAL}};
        else     sh_q <= sh_d;
    end

    assign q = sh_q[1];
endmodule

// File: rtl/sup_stuck_det.sv
module sup_stuck_det #(
    parameter int W        = 4,
    parameter int SET_CYC  = 16,
    parameter int SLOT_CYC = 8,
    parameter int SLOTS    = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] word,
    output logic         los
);
    localparam int SW = $clog2(SET_CYC + 1);
    localparam int TW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam int GW = $clog2(SLOTS + 1);

    typedef struct packed {
        logic          last;
        logic [SW-1:0] stuck;
        logic [TW-1:0] slot;
        logic          seen;
        logic [GW-1:0] good;
        logic          los;
    } det_t;

    det_t st_d, st_q;
    logic [W-1:0] diff;
    logic         trans;

    // bit W-1 is oldest: compare with newest bit of previous word
    assign diff[W-1] = word[W-1] ^ st_q.last;
    for (genvar i = 0; i < W - 1; i++) begin : g_adj
        assign diff[i] = word[i] ^ word[i+1];
    end
    assign trans = |diff;

    always_comb begin
        st_d      = st_q;
        st_d.last = word[0];
        if (!st_q.los) begin
            if (trans)                        st_d.stuck = '0;
            else if (st_q.stuck != SW'(SET_CYC)) st_d.stuck = st_q.stuck + 1'b1;
            if (st_d.stuck == SW'(SET_CYC)) begin
                st_d.los  = 1'b1;
                st_d.slot = '0;
                st_d.seen = 1'b0;
                st_d.good = '0;
            end
        end else begin
            st_d.seen = st_q.seen | trans;
            if (st_q.slot == TW'(SLOT_CYC - 1)) begin
                st_d.slot = '0;
                st_d.seen = 1'b0;
                if (st_q.seen | trans) st_d.good = st_q.good + 1'b1;
                else                   st_d.good = '0;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
            if (st_d.good == GW'(SLOTS)) begin
                st_d.los   = 1'b0;
                st_d.stuck = '0;
                st_d.good  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign los = st_q.los;
endmodule

// File: rtl/sup_lock_filt.sv
module sup_lock_filt #(
    parameter int SET_CYC = 40,
    parameter int CLR_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic locked,
    output logic lol
);
    localparam int MAXC = (SET_CYC > CLR_CYC) ? SET_CYC : CLR_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lol;
    } filt_t;

    filt_t st_d, st_q;
    logic [CW-1:0] limit;

    assign limit = st_q.lol ? CW'(CLR_CYC) : CW'(SET_CYC);

    always_comb begin
        st_d = st_q;
        // evidence for a change: lock matches current loss flag
        if (locked == st_q.lol) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt == limit) begin
                st_d.lol = ~st_q.lol;
                st_d.cnt = '0;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lol = st_q.lol;
endmodule

// File: rtl/rx_sig_supervisor.sv
module rx_sig_supervisor
    import sup_pkg::*;
#(
    parameter int DATA_W        = 4,
    parameter int LOS_SET_CYC   = 16,
    parameter int LOS_SLOT_CYC  = 8,
    parameter int LOS_CLR_SLOTS = 4,
    parameter int LOL_SET_CYC   = 40,
    parameter int LOL_CLR_CYC   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              pll_lock_raw,
    output logic [DATA_W-1:0] rx_data_out,
    output logic              los_n,
    output logic              lol_n,
    output logic              use_refclk,
    output logic [1:0]        op_state
);
    logic              los_q, lol_q, lock_s;
    logic [DATA_W-1:0] data_d, data_q;
    sup_state_e        state;

    sup_stuck_det #(
        .W(DATA_W), .SET_CYC(LOS_SET_CYC),
        .SLOT_CYC(LOS_SLOT_CYC), .SLOTS(LOS_CLR_SLOTS)
    ) u_det (
        .clk(clk), .rst(rst), .word(rx_word), .los(los_q)
    );

    sup_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(pll_lock_raw), .q(lock_s)
    );

    sup_lock_filt #(.SET_CYC(LOL_SET_CYC), .CLR_CYC(LOL_CLR_CYC)) u_filt (
        .clk(clk), .rst(rst), .locked(lock_s), .lol(lol_q)
    );

    always_comb begin
        data_d = rx_word;
        if (los_q)      state = ST_CLEAN_LOS;
        else if (lol_q) state = ST_DIRTY;
        else            state = ST_NORMAL;
    end

    always_ff @(posedge clk) begin
        if (rst) data_q <= '0;
        else     data_q <= data_d;
    end

    assign rx_data_out = los_q ? '0 : data_q;
    assign los_n       = ~los_q;
    assign lol_n       = ~(lol_q & ~los_q);
    assign use_refclk  = los_q;
    assign op_state    = state;
endmodule

// File: rtl/rx_sig_supervisor_chk.sv
module rx_sig_supervisor_chk #(
    parameter int DATA_W        = 4,
    parameter int LOS_SLOT_CYC  = 8,
    parameter int LOS_CLR_SLOTS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] rx_word,
    input logic [DATA_W-1:0] rx_data_out,
    input logic              los_n,
    input logic              lol_n,
    input logic              use_refclk,
    input logic [1:0]        op_state
);
    localparam int WIN = LOS_SLOT_CYC * LOS_CLR_SLOTS;

    logic        prev_bit;
    logic        trans_c;
    logic [15:0] lost_cnt;

    assign trans_c = (rx_word[DATA_W-1] != prev_bit) ||
                     (rx_word[DATA_W-2:0] != rx_word[DATA_W-1:1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_bit <= 1'b0;
            lost_cnt <= '0;
        end else begin
            prev_bit <= rx_word[0];
            if (los_n)                  lost_cnt <= '0;
            else if (lost_cnt != 16'hFFFF) lost_cnt <= lost_cnt + 1'b1;
        end
    end

    assert_quiet_before_set_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(los_n) |-> $past(!trans_c));

    assert_zero_data_R4: assert property (@(posedge clk) disable iff (rst)
        !los_n |-> rx_data_out == '0);

    assert_refclk_follows_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(los_n) |-> $rose(use_refclk));

    assert_full_window_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(los_n) |-> lost_cnt >= 16'(WIN));

    assert_clean_code_R9: assert property (@(posedge clk) disable iff (rst)
        op_state == 2'd1 |-> (!los_n && lol_n));

    assert_dirty_code_R9: assert property (@(posedge clk) disable iff (rst)
        op_state == 2'd2 |-> (los_n && !lol_n));

    assert_lol_masked_R9: assert property (@(posedge clk) disable iff (rst)
        !los_n |-> lol_n);
endmodule

bind rx_sig_supervisor rx_sig_supervisor_chk #(
    .DATA_W(DATA_W), .LOS_SLOT_CYC(LOS_SLOT_CYC), .LOS_CLR_SLOTS(LOS_CLR_SLOTS)
) u_chk (
    .clk(clk), .rst(rst), .rx_word(rx_word), .rx_data_out(rx_data_out),
    .los_n(los_n), .lol_n(lol_n), .use_refclk(use_refclk), .op_state(op_state)
);

// File: tb/rx_sig_supervisor_test.sv
module rx_sig_supervisor_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] rx_word = 4'h0;
    logic       pll_lock_raw = 1'b1;
    logic [3:0] rx_data_out;
    logic       los_n, lol_n, use_refclk;
    logic [1:0] op_state;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [3:0] VEC [8] = '{4'hA, 4'h5, 4'h3, 4'hC, 4'hF, 4'h0, 4'h9, 4'h6};

    always #10 clk = ~clk;

    rx_sig_supervisor uut (
        .clk(clk), .rst(rst), .rx_word(rx_word), .pll_lock_raw(pll_lock_raw),
        .rx_data_out(rx_data_out), .los_n(los_n), .lol_n(lol_n),
        .use_refclk(use_refclk), .op_state(op_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] w, input int n = 1);
        for (int i = 0; i < n; i++) begin
            rx_word = w;
            @(negedge clk);
        end
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk("R1 los_n", los_n, 1);
        chk("R1 lol_n", lol_n, 1);
        chk("R1 use_refclk", use_refclk, 0);
        chk("R1 op_state", op_state, 0);
        chk("R1 data", rx_data_out, 0);
        rst = 1'b0;

        // R4 table walk: data follows input one edge later
        for (int i = 0; i < 8; i++) begin
            cyc(VEC[i]);
            chk("R4 passthrough", rx_data_out, VEC[i]);
            chk("R3 no loss while toggling", los_n, 1);
        end

        // R3 set timing
        cyc(4'h0, 15);
        chk("R3 one short", los_n, 1);
        cyc(4'h0);
        chk("R3 set", los_n, 0);
        chk("R5 refclk on", use_refclk, 1);
        chk("R9 clean code", op_state, 1);
        chk("R4 forced zero", rx_data_out, 0);

        // R6 clear window with a quiet slot restarting it
        cyc(4'hA, 24);
        chk("R4 forced zero under toggling", rx_data_out, 0);
        cyc(4'h0, 8);
        chk("R6 still lost after quiet slot", los_n, 0);
        cyc(4'hA, 31);
        chk("R6 one short", los_n, 0);
        cyc(4'hA);
        chk("R6 cleared", los_n, 1);
        chk("R5 refclk off", use_refclk, 0);
        chk("R9 normal code", op_state, 0);
        chk("R4 data resumes", rx_data_out, 4'hA);

        // R2 boundary-only transition resets the stuck run
        cyc(4'h0, 15);
        cyc(4'hF);
        chk("R2 boundary transition", los_n, 1);
        cyc(4'hF, 15);
        chk("R2 run restarted", los_n, 1);
        cyc(4'hF);
        chk("R2 set after full run", los_n, 0);
        cyc(4'hA, 32);
        chk("R6 recovered", los_n, 1);

        // R7 lock loss timing
        pll_lock_raw = 1'b0;
        cyc(4'hA, 41);
        chk("R7 one short", lol_n, 1);
        cyc(4'hA);
        chk("R7 set", lol_n, 0);
        chk("R9 dirty code", op_state, 2);
        chk("R9 los_n in dirty", los_n, 1);
        cyc(4'h5);
        chk("R10 data not forced", rx_data_out, 4'h5);

        // R8 lock clear timing
        pll_lock_raw = 1'b1;
        cyc(4'hA, 21);
        chk("R8 one short", lol_n, 0);
        cyc(4'hA);
        chk("R8 cleared", lol_n, 1);

        // R9 precedence of signal loss over lock loss
        pll_lock_raw = 1'b0;
        cyc(4'hA, 42);
        chk("R7 set again", lol_n, 0);
        cyc(4'h0, 16);
        chk("R9 clean wins", op_state, 1);
        chk("R9 lol masked", lol_n, 1);
        pll_lock_raw = 1'b1;
        cyc(4'hA, 32);
        chk("R9 back to normal", op_state, 0);
        chk("R9 lol clear", lol_n, 1);
        chk("R6 final clear", los_n, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule